// File: doc/BRIEF.md
# Status LED Blink Pattern Generator

The block drives two status LEDs, one green and one red, so that a person looking at a board can tell which power-up stage is active or which fault is present. Each LED plays an eight-slot frame that repeats. A slot is either lit or dark, and the number of lit slots in a frame identifies the condition. An internal prescaler sets the slot period. Both LEDs use the same slot counter, so their frames always begin on the same clock edge.

The green LED follows a 3-bit sequencer state code. The idle and ready codes give a steady LED that reacts within one clock. The five stage codes and the wait-for-ready code give blinking frames. The red LED shows the highest-priority condition that is active among six inputs: a supply-good flag, a manual reset, a processor software reset, a configuration-done flag, a configuration-busy flag and a USB bridge power enable. Blinking patterns are captured only at a frame boundary, so a partial frame is never shown.

Top module: `status_led_blinker`

## Requirements
- R1: After reset, and until the first frame boundary, both LEDs are dark (0) whatever the inputs are, except for the steady green codes of R4.
- R2: Green state codes 1 to 5 (stage n = code) give a frame in which slots 0 to 7−n are dark and slots 8−n to 7 are lit.
- R3: Green code 6 (wait-for-ready) lights all eight slots. Like the stage codes, it takes effect only at a frame boundary.
- R4: Green code 0 (idle) holds the green LED steadily dark, and code 7 (ready) holds it steadily lit. Either one takes effect one clock after it is presented, at any point in the frame.
- R5: When the green code leaves 0 or 7 in the middle of a frame, the green LED is dark until the next frame boundary, and the new pattern starts from that boundary.
- R6: Red patterns light slots 0 to k−1 and leave the rest dark. The count k is 8 when `supply_ok` = 0, 5 when `man_rst_n` = 0, 4 when `sw_rst_n` = 0, 3 when `cfg_done` = 0, 2 when `cfg_busy` = 1, and 1 when `usb_pwr_en_n` = 1.
- R7: When several red conditions are active at once, the one listed first in R6 wins.
- R8: When no red condition is active, the red LED stays dark for the whole frame.
- R9: A change on any pattern-selecting input in the middle of a frame has no effect on the rest of that frame (except as R4 and R5 describe). The new pattern appears from the next frame boundary.
- R10: Each slot lasts TICK_DIV clocks. Slot 0 of the first frame starts with the second rising edge after `rst_n` is released, and a new frame starts every 8·TICK_DIV clocks. Both LEDs share this alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_state | input | 3 | Sequencer state code: 0 idle, 1 to 5 stage, 6 wait-for-ready, 7 ready |
| supply_ok | input | 1 | High when all supplies are good |
| man_rst_n | input | 1 | Manual reset, active low |
| sw_rst_n | input | 1 | Processor software reset, active low |
| cfg_done | input | 1 | High when configuration has completed |
| cfg_busy | input | 1 | High while configuration is in progress |
| usb_pwr_en_n | input | 1 | USB bridge power enable, active low |
| led_green | output | 1 | Green LED drive, active high |
| led_red | output | 1 | Red LED drive, active high |

## Verification
The slot counter is the single point of failure for timing. If it advances at the wrong rate or drifts, every later frame shows up shifted against the bench's own count, starting with the first frame after reset. A wrong latched pattern is visible within one frame as the wrong count of lit slots. A capture register that updates mid-frame shows a mixed frame on the very frame in which an input changes. A broken steady path shows up one clock after the idle or ready code is presented, and a missing blank on leaving ready shows up as lit slots before the next boundary.

// File: rtl/led_pat_pkg.sv
package led_pat_pkg;

  localparam int FRAME_SLOTS = 8;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);

  typedef enum logic [2:0] {
    PS_IDLE   = 3'd0,
    PS_STAGE1 = 3'd1,
    PS_STAGE2 = 3'd2,
    PS_STAGE3 = 3'd3,
    PS_STAGE4 = 3'd4,
    PS_STAGE5 = 3'd5,
    PS_WAIT   = 3'd6,
    PS_READY  = 3'd7
  } pwr_state_e;

  // n lit slots at the end of the frame
  function automatic logic [FRAME_SLOTS-1:0] tail_lit(input int n);
    logic [FRAME_SLOTS-1:0] m;
    m = '1;
    m = m << (FRAME_SLOTS - n);
    return m;
  endfunction

  // n lit slots at the start of the frame
  function automatic logic [FRAME_SLOTS-1:0] head_lit(input int n);
    logic [FRAME_SLOTS-1:0] m;
    m = '1;
    m = m << n;
    return ~m;
  endfunction

endpackage

// File: rtl/led_slot_timer.sv
module led_slot_timer #(
  parameter int TICK_DIV = 12_500_000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic                         tick,
  output logic [led_pat_pkg::SLOT_W-1:0] slot
);
  localparam int CW = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV);
  localparam logic [CW-1:0] CNT_LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0]                   cnt_q, cnt_d;
  logic [led_pat_pkg::SLOT_W-1:0]  slot_q, slot_d;

  assign tick = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    slot_d = tick ? slot_q + 1'b1 : slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  assign slot = slot_q;

endmodule

// File: rtl/led_green_map.sv
module led_green_map
  import led_pat_pkg::*;
(
  input  logic [2:0]             state,
  output logic [FRAME_SLOTS-1:0] mask,
  output logic                   steady,
  output logic                   steady_val
);
  always_comb begin
    mask       = '0;
    steady     = 1'b0;
    steady_val = 1'b0;
    case (pwr_state_e'(state))
      PS_IDLE: begin
        steady = 1'b1;
      end
      PS_READY: begin
        mask       = '1;
        steady     = 1'b1;
        steady_val = 1'b1;
      end
      PS_WAIT: mask = '1;
      default: mask = tail_lit(int'(state));
    endcase
  end
endmodule

// File: rtl/led_red_prio.sv
module led_red_prio
  import led_pat_pkg::*;
(
  input  logic                   supply_ok,
  input  logic                   man_rst_n,
  input  logic                   sw_rst_n,
  input  logic                   cfg_done,
  input  logic                   cfg_busy,
  input  logic                   usb_pwr_en_n,
  output logic [FRAME_SLOTS-1:0] mask
);
  always_comb begin
    if (!supply_ok)        mask = head_lit(8);
    else if (!man_rst_n)   mask = head_lit(5);
    else if (!sw_rst_n)    mask = head_lit(4);
    else if (!cfg_done)    mask = head_lit(3);
    else if (cfg_busy)     mask = head_lit(2);
    else if (usb_pwr_en_n) mask = head_lit(1);
    else                   mask = '0;
  end
endmodule

// File: rtl/led_frame_reg.sv
module led_frame_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_n;

  always_comb begin
    if (load)       q_n = d;
    else if (clear) q_n = '0;
    else            q_n = q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_n;
  end

  assign q = q_r;
endmodule

// File: rtl/status_led_blinker.sv
module status_led_blinker
  import led_pat_pkg::*;
#(
  parameter int TICK_DIV = 12_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pwr_state,
  input  logic       supply_ok,
  input  logic       man_rst_n,
  input  logic       sw_rst_n,
  input  logic       cfg_done,
  input  logic       cfg_busy,
  input  logic       usb_pwr_en_n,
  output logic       led_green,
  output logic       led_red
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              tick;
  logic [SLOT_W-1:0] slot;
  logic              frame_edge;

  led_slot_timer #(.TICK_DIV(TICK_DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick),
    .slot  (slot)
  );

  assign frame_edge = tick && (slot == LAST_SLOT);

  logic [FRAME_SLOTS-1:0] g_mask_d, r_mask_d, g_mask_q, r_mask_q;
  logic                   g_steady_d, g_val_d;

  led_green_map u_gmap (
    .state      (pwr_state),
    .mask       (g_mask_d),
    .steady     (g_steady_d),
    .steady_val (g_val_d)
  );

  led_red_prio u_rprio (
    .supply_ok    (supply_ok),
    .man_rst_n    (man_rst_n),
    .sw_rst_n     (sw_rst_n),
    .cfg_done     (cfg_done),
    .cfg_busy     (cfg_busy),
    .usb_pwr_en_n (usb_pwr_en_n),
    .mask         (r_mask_d)
  );

  // steady green bypass, refreshed every clock
  logic g_steady_q, g_val_q;
  logic g_steady_n, g_val_n;

  always_comb begin
    g_steady_n = g_steady_d;
    g_val_n    = g_val_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      g_steady_q <= 1'b0;
      g_val_q    <= 1'b0;
    end else begin
      g_steady_q <= g_steady_n;
      g_val_q    <= g_val_n;
    end
  end

  led_frame_reg #(.W(FRAME_SLOTS)) u_gframe (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (frame_edge),
    .clear (g_steady_q),
    .d     (g_mask_d),
    .q     (g_mask_q)
  );

  led_frame_reg #(.W(FRAME_SLOTS)) u_rframe (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (frame_edge),
    .clear (1'b0),
    .d     (r_mask_d),
    .q     (r_mask_q)
  );

  assign led_green = g_steady_q ? g_val_q : g_mask_q[slot];
  assign led_red   = r_mask_q[slot];

endmodule

// File: rtl/status_led_blinker_chk.sv
module status_led_blinker_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [2:0] pwr_state,
  input logic       supply_ok,
  input logic       tick,
  input logic [2:0] slot,
  input logic       frame_edge,
  input logic [7:0] g_mask_q,
  input logic [7:0] r_mask_q,
  input logic       g_steady_q,
  input logic       led_green,
  input logic       led_red
);
  a_r4_ready_on: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && pwr_state == 3'd7) |=> led_green);

  a_r4_idle_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && pwr_state == 3'd0) |=> !led_green);

  a_r10_slot_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && tick) |=> (slot == $past(slot) + 3'd1));

  a_r10_slot_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && !tick) |=> $stable(slot));

  a_r9_red_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && !frame_edge) |=> $stable(r_mask_q));

  a_r7_fault_top: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rst_sync_n && frame_edge && !supply_ok) |=> (r_mask_q == 8'hFF));

  a_r6_red_head: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (led_red && slot != 3'd0) |-> r_mask_q[slot - 3'd1]);

  a_r2_green_tail: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!g_steady_q && led_green && slot != 3'd7) |-> g_mask_q[slot + 3'd1]);
endmodule

bind status_led_blinker status_led_blinker_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .pwr_state  (pwr_state),
  .supply_ok  (supply_ok),
  .tick       (tick),
  .slot       (slot),
  .frame_edge (frame_edge),
  .g_mask_q   (g_mask_q),
  .r_mask_q   (r_mask_q),
  .g_steady_q (g_steady_q),
  .led_green  (led_green),
  .led_red    (led_red)
);

// File: tb/sim_status_led_blinker.sv
`timescale 1ns/1ps
module sim_status_led_blinker;
  localparam int DIV   = 4;
  localparam int FRAME = 8 * DIV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] pwr_state;
  logic       supply_ok, man_rst_n, sw_rst_n, cfg_done, cfg_busy, usb_pwr_en_n;
  logic       led_green, led_red;

  int n_tests = 0;
  int n_fail  = 0;
  int ecount  = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  status_led_blinker #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state),
    .supply_ok(supply_ok), .man_rst_n(man_rst_n), .sw_rst_n(sw_rst_n),
    .cfg_done(cfg_done), .cfg_busy(cfg_busy), .usb_pwr_en_n(usb_pwr_en_n),
    .led_green(led_green), .led_red(led_red)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tail_exp(input int n);
    logic [7:0] m = '0;
    for (int s = 0; s < 8; s++) m[s] = (s >= 8 - n);
    return m;
  endfunction

  function automatic logic [7:0] head_exp(input int n);
    logic [7:0] m = '0;
    for (int s = 0; s < 8; s++) m[s] = (s < n);
    return m;
  endfunction

  task automatic set_quiet();
    supply_ok = 1'b1; man_rst_n = 1'b1; sw_rst_n = 1'b1;
    cfg_done = 1'b1; cfg_busy = 1'b0; usb_pwr_en_n = 1'b0;
  endtask

  // stop at the first negedge after a frame-boundary edge
  task automatic wait_frame_start();
    @(negedge clk);
    while (!(ecount > 2 && ((ecount - 2) % FRAME) == 0)) @(negedge clk);
  endtask

  // sample one point per slot over a whole frame
  task automatic check_frame(input logic [7:0] eg, input logic [7:0] er,
                             input string req, input string what);
    logic [7:0] ag, ar;
    for (int s = 0; s < 8; s++) begin
      ag[s] = led_green;
      ar[s] = led_red;
      repeat (DIV) @(negedge clk);
    end
    check(ag == eg, req, {what, " green"}, ag, eg);
    check(ar == er, req, {what, " red"}, ar, er);
  endtask

  task automatic t_reset();
    logic bad;
    set_quiet();
    supply_ok = 1'b0;
    pwr_state = 3'd1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!led_green && !led_red, "R1", "during reset", {led_green, led_red}, 0);
    rst_n = 1'b1;
    bad = 1'b0;
    while (ecount < FRAME + 2) begin
      @(negedge clk);
      if (ecount < FRAME + 2 && (led_green || led_red)) bad = 1'b1;
    end
    check(!bad, "R1", "dark before first boundary", bad, 0);
    check(led_red == 1'b1, "R10", "red lit at first frame start", led_red, 1);
    check_frame(tail_exp(1), head_exp(8), "R10", "first frame alignment");
  endtask

  task automatic t_green_stages();
    set_quiet();
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      pwr_state = 3'(n);
      wait_frame_start();
      check_frame(tail_exp(n), 8'h00, "R2", $sformatf("stage %0d", n));
    end
    @(negedge clk);
    pwr_state = 3'd6;
    wait_frame_start();
    check_frame(8'hFF, 8'h00, "R3", "wait-for-ready");
  endtask

  task automatic t_green_steady();
    wait_frame_start();
    repeat (DIV * 2 + 1) @(negedge clk);
    pwr_state = 3'd7;
    @(negedge clk);
    check(led_green == 1'b1, "R4", "ready on after one clock", led_green, 1);
    repeat (3) @(negedge clk);
    pwr_state = 3'd0;
    @(negedge clk);
    check(led_green == 1'b0, "R4", "idle off after one clock", led_green, 0);
    pwr_state = 3'd7;
    wait_frame_start();
    check_frame(8'hFF, 8'h00, "R4", "ready steady frame");
  endtask

  task automatic t_leave_steady();
    logic bad;
    pwr_state = 3'd7;
    wait_frame_start();
    repeat (DIV * 3) @(negedge clk);
    pwr_state = 3'd3;
    bad = 1'b0;
    @(negedge clk);
    while (!(((ecount - 2) % FRAME) == 0)) begin
      if (led_green) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R5", "dark after leaving ready", bad, 0);
    check_frame(tail_exp(3), 8'h00, "R5", "stage 3 after ready");
  endtask

  task automatic t_red_single();
    pwr_state = 3'd0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      set_quiet();
      case (c)
        0: supply_ok = 1'b0;
        1: man_rst_n = 1'b0;
        2: sw_rst_n = 1'b0;
        3: cfg_done = 1'b0;
        4: cfg_busy = 1'b1;
        default: usb_pwr_en_n = 1'b1;
      endcase
      wait_frame_start();
      check_frame(8'h00, head_exp(c == 0 ? 8 : 6 - c), "R6",
                  $sformatf("single condition %0d", c));
    end
  endtask

  task automatic t_red_priority();
    @(negedge clk);
    set_quiet(); supply_ok = 1'b0; man_rst_n = 1'b0; usb_pwr_en_n = 1'b1;
    wait_frame_start();
    check_frame(8'h00, head_exp(8), "R7", "supply over manual reset");
    set_quiet(); man_rst_n = 1'b0; sw_rst_n = 1'b0; cfg_done = 1'b0;
    wait_frame_start();
    check_frame(8'h00, head_exp(5), "R7", "manual over software reset");
    set_quiet(); sw_rst_n = 1'b0; cfg_busy = 1'b1;
    wait_frame_start();
    check_frame(8'h00, head_exp(4), "R7", "software reset over busy");
    set_quiet(); cfg_done = 1'b0; cfg_busy = 1'b1; usb_pwr_en_n = 1'b1;
    wait_frame_start();
    check_frame(8'h00, head_exp(3), "R7", "not-done over busy");
    set_quiet(); cfg_busy = 1'b1; usb_pwr_en_n = 1'b1;
    wait_frame_start();
    check_frame(8'h00, head_exp(2), "R7", "busy over usb");
  endtask

  task automatic t_red_off();
    @(negedge clk);
    set_quiet();
    wait_frame_start();
    check_frame(8'h00, 8'h00, "R8", "no red condition");
  endtask

  task automatic t_mid_frame();
    logic [7:0] ar, er;
    @(negedge clk);
    set_quiet(); man_rst_n = 1'b0; pwr_state = 3'd2;
    wait_frame_start();
    check_frame(tail_exp(2), head_exp(5), "R9", "before change");
    er = head_exp(5);
    for (int s = 0; s < 8; s++) begin
      ar[s] = led_red;
      if (s == 3) begin
        man_rst_n = 1'b1; sw_rst_n = 1'b0; pwr_state = 3'd5;
      end
      repeat (DIV) @(negedge clk);
    end
    check(ar == er, "R9", "frame with mid-frame change", ar, er);
    check_frame(tail_exp(5), head_exp(4), "R9", "frame after change");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_green_stages();
    t_green_steady();
    t_leave_steady();
    t_red_single();
    t_red_priority();
    t_red_off();
    t_mid_frame();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule